// File: doc/BRIEF.md
# Link-On Wake-Up Signal Generator

This block drives the link-on line. A physical-layer device uses that line to tell a sleeping link-layer controller to power up. The block watches two things: a link power-status input and a link-control bit. From them it decides whether the link is currently asleep. While the link is asleep, a wake-up cause arms a sticky request. A wake-up cause is either a received link-on packet whose target node ID equals the local node ID, or a pending interrupt in the physical layer. While the request is held, the block drives a free-running square wave. Otherwise the output stays low.

The request is dropped in two cases. The first is when the link reports itself awake, meaning power status is high and the control bit is 1. The second is a bus reset, provided no interrupt is still pending at that moment. Packet parsing and interrupt sources lie outside the block and arrive as decoded signals. The half-period of the wave is a count of base-clock cycles set by a parameter. At a 49.152 MHz base clock, the default of 4 gives a period of about 163 ns.

Top module: `lkon_wake_gen`

## Requirements
- R1: After reset, and whenever no wake-up request is held, `link_on_o` is 0.
- R2: The link counts as asleep when `link_pwr_i` is 0 or `link_ctl_i` is 0. A cycle with both at 1 clears the request, and `link_on_o` is 0 two cycles after that cycle is sampled.
- R3: A wake-up cause sampled while the link is asleep sets the request, and `link_on_o` goes high two clock edges later. A wake-up cause is `pkt_valid_i` with `pkt_dest_i` equal to `local_id_i`, or `phy_irq_i` at 1.
- R4: Wake-up causes sampled while the link is awake have no effect, and `link_on_o` stays 0.
- R5: A link-on packet whose `pkt_dest_i` differs from `local_id_i` is ignored.
- R6: While the request is held, `link_on_o` repeats HALF_CYC cycles high and then HALF_CYC cycles low, starting high.
- R7: A `bus_rst_i` pulse sampled while `phy_irq_i` is 0 clears the request, and `link_on_o` is 0 two cycles later.
- R8: A `bus_rst_i` pulse sampled while `phy_irq_i` is 1 leaves the wave running without a break.
- R9: The request is sticky. It remains after the packet pulse or the interrupt level has gone away.
- R10: A bus reset with no pending interrupt takes priority over a matching packet in the same cycle, so no request is set.
- R11: Each new activation after a clear begins with a full HALF_CYC-cycle high phase, even when the previous wave was stopped in the middle of a high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_pwr_i | input | 1 | Link power status, 1 = powered |
| link_ctl_i | input | 1 | Link-control bit, 1 = link enabled |
| pkt_valid_i | input | 1 | One-cycle pulse: a link-on packet was received |
| pkt_dest_i | input | NODE_W | Target node ID of that packet |
| local_id_i | input | NODE_W | This node's ID |
| phy_irq_i | input | 1 | Interrupt-pending level from the physical layer |
| bus_rst_i | input | 1 | One-cycle bus-reset pulse |
| link_on_o | output | 1 | Link-on square wave |

## Verification
The bench sweeps every pair of local ID and packet target with 6-bit IDs. A comparator that matched loosely, for example on a subset of bits, would then wake the link for a foreign packet. It also varies which of the two asleep conditions holds, so a design that required both to be low would be caught. The wave is checked cycle by cycle for the default half-period and for a half-period of 1. A counter that was off by one, or that started low after a restart, would shift the pattern. A restart after a stop in mid-pulse must produce a full-width first pulse, not a runt. Bus reset is tested three ways: alone, with an interrupt still pending, and together with a matching packet. A design that got the blocking or the priority wrong would either stop a wave that must keep running or leave a request that must be gone.

// File: rtl/lkon_pkg.sv
package lkon_pkg;

   // Decision taken on the wake-up request in one cycle
   typedef enum logic [1:0] {
      REQ_HOLD    = 2'd0,
      REQ_SET     = 2'd1,
      REQ_CLR_ACT = 2'd2,
      REQ_CLR_RST = 2'd3
   } req_act_e;

   // Counter width needed to count 0 .. n-1, never below 1
   function automatic int cnt_width(input int n);
      int w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/lkon_addr_match.sv
module lkon_addr_match #(
   parameter int NODE_W = 6
) (
   input  logic              pkt_valid_i,
   input  logic [NODE_W-1:0] pkt_dest_i,
   input  logic [NODE_W-1:0] local_id_i,
   output logic              hit_o
);

   initial assert (NODE_W >= 1) else $error("lkon_addr_match: NODE_W must be at least 1");

   logic [NODE_W-1:0] diff;

   // Bit-wise difference, reduced below; a hit needs every bit equal
   generate
      for (genvar b = 0; b < NODE_W; b++) begin : g_bit
         assign diff[b] = pkt_dest_i[b] ^ local_id_i[b];
      end
   endgenerate

   assign hit_o = pkt_valid_i && (diff == '0);

endmodule

// File: rtl/lkon_req_ctrl.sv
module lkon_req_ctrl
   import lkon_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic link_pwr_i,
   input  logic link_ctl_i,
   input  logic pkt_hit_i,
   input  logic phy_irq_i,
   input  logic bus_rst_i,
   output logic idle_o,
   output logic req_o
);

   req_act_e act;
   logic     req_q;
   logic     wake_evt;

   assign idle_o   = !(link_pwr_i && link_ctl_i);
   assign wake_evt = pkt_hit_i || phy_irq_i;

   // Priority: awake link, then unblocked bus reset, then wake-up cause
   always_comb begin
      act = REQ_HOLD;
      if (!idle_o) begin
         act = REQ_CLR_ACT;
      end else if (bus_rst_i && !phy_irq_i) begin
         act = REQ_CLR_RST;
      end else if (wake_evt) begin
         act = REQ_SET;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else begin
         unique case (act)
            REQ_SET:     req_q <= 1'b1;
            REQ_CLR_ACT,
            REQ_CLR_RST: req_q <= 1'b0;
            default:     req_q <= req_q;
         endcase
      end
   end

   assign req_o = req_q;

endmodule

// File: rtl/lkon_sqwave.sv
module lkon_sqwave
   import lkon_pkg::*;
#(
   parameter int HALF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic wave_o
);

   initial assert (HALF_CYC >= 1) else $error("lkon_sqwave: HALF_CYC must be at least 1");

   logic run_q;
   logic hi_q;

   generate
      if (HALF_CYC == 1) begin : g_toggle
         // One cycle per phase: toggle every cycle, no counter needed
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= 1'b0;
               hi_q  <= 1'b0;
            end else if (!req_i) begin
               run_q <= 1'b0;
               hi_q  <= 1'b0;
            end else if (!run_q) begin
               run_q <= 1'b1;
               hi_q  <= 1'b1;
            end else begin
               hi_q  <= ~hi_q;
            end
         end
      end else begin : g_count
         localparam int CNT_W = cnt_width(HALF_CYC);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= 1'b0;
               hi_q  <= 1'b0;
               cnt_q <= '0;
            end else if (!req_i) begin
               run_q <= 1'b0;
               hi_q  <= 1'b0;
               cnt_q <= '0;
            end else if (!run_q) begin
               // Fresh start: full high phase
               run_q <= 1'b1;
               hi_q  <= 1'b1;
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
               hi_q  <= ~hi_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   assign wave_o = hi_q;

endmodule

// File: rtl/lkon_wake_gen.sv
module lkon_wake_gen #(
   parameter int NODE_W   = 6,
   parameter int HALF_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_pwr_i,
   input  logic              link_ctl_i,
   input  logic              pkt_valid_i,
   input  logic [NODE_W-1:0] pkt_dest_i,
   input  logic [NODE_W-1:0] local_id_i,
   input  logic              phy_irq_i,
   input  logic              bus_rst_i,
   output logic              link_on_o
);

   initial assert (NODE_W >= 1 && HALF_CYC >= 1)
      else $error("lkon_wake_gen: bad parameters");

   logic pkt_hit;
   logic link_idle;
   logic wake_req;

   lkon_addr_match #(.NODE_W(NODE_W)) u_match (
      .pkt_valid_i (pkt_valid_i),
      .pkt_dest_i  (pkt_dest_i),
      .local_id_i  (local_id_i),
      .hit_o       (pkt_hit)
   );

   lkon_req_ctrl u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .link_pwr_i (link_pwr_i),
      .link_ctl_i (link_ctl_i),
      .pkt_hit_i  (pkt_hit),
      .phy_irq_i  (phy_irq_i),
      .bus_rst_i  (bus_rst_i),
      .idle_o     (link_idle),
      .req_o      (wake_req)
   );

   lkon_sqwave #(.HALF_CYC(HALF_CYC)) u_wave (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (wake_req),
      .wave_o (link_on_o)
   );

endmodule

// File: rtl/lkon_wake_chk.sv
module lkon_wake_chk #(
   parameter int HALF_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic idle,
   input logic req,
   input logic pkt_hit,
   input logic phy_irq,
   input logic bus_rst,
   input logic link_on
);

   logic [15:0] hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 hi_len <= '0;
      else if (!link_on)          hi_len <= '0;
      else if (hi_len != 16'hFFFF) hi_len <= hi_len + 16'd1;
   end

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!req && $past(!req)) |-> !link_on); // R1

   AST_AWAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> !req); // R2

   AST_SET_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> $past(idle && (pkt_hit || phy_irq))); // R3

   AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      link_on |-> (hi_len < 16'(HALF_CYC))); // R6

   AST_BUS_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rst && !phy_irq) |=> !req); // R7

   AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |=> link_on); // R11

endmodule

bind lkon_wake_gen lkon_wake_chk #(.HALF_CYC(HALF_CYC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .idle    (link_idle),
   .req     (wake_req),
   .pkt_hit (pkt_hit),
   .phy_irq (phy_irq_i),
   .bus_rst (bus_rst_i),
   .link_on (link_on_o)
);

// File: tb/test_lkon_wake_gen.sv
module test_lkon_wake_gen;

   localparam int NW = 6;
   localparam int H  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          link_pwr = 1'b1;
   logic          link_ctl = 1'b1;
   logic          pkt_valid = 1'b0;
   logic [NW-1:0] pkt_dest = '0;
   logic [NW-1:0] local_id = '0;
   logic          phy_irq = 1'b0;
   logic          bus_rst = 1'b0;
   logic          link_on;
   logic          link_on_h1;

   int nchk  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   lkon_wake_gen #(.NODE_W(NW), .HALF_CYC(H)) i_lkon_wake_gen (
      .clk(clk), .rst_n(rst_n), .link_pwr_i(link_pwr), .link_ctl_i(link_ctl),
      .pkt_valid_i(pkt_valid), .pkt_dest_i(pkt_dest), .local_id_i(local_id),
      .phy_irq_i(phy_irq), .bus_rst_i(bus_rst), .link_on_o(link_on)
   );

   lkon_wake_gen #(.NODE_W(NW), .HALF_CYC(1)) i_lkon_wake_gen_h1 (
      .clk(clk), .rst_n(rst_n), .link_pwr_i(link_pwr), .link_ctl_i(link_ctl),
      .pkt_valid_i(pkt_valid), .pkt_dest_i(pkt_dest), .local_id_i(local_id),
      .phy_irq_i(phy_irq), .bus_rst_i(bus_rst), .link_on_o(link_on_h1)
   );

   task automatic check(input string req, input logic act, input logic exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // Called one negedge after the start pulse was removed
   task automatic check_wave(input string req, input int ncyc);
      for (int k = 0; k < ncyc; k++) begin
         @(negedge clk);
         check(req, link_on, ((k / H) % 2) == 0);
         check(req, link_on_h1, (k % 2) == 0);
      end
   endtask

   task automatic check_low(input string req, input int ncyc);
      for (int k = 0; k < ncyc; k++) begin
         @(negedge clk);
         check(req, link_on, 1'b0);
         check(req, link_on_h1, 1'b0);
      end
   endtask

   // Wake the link: both inputs high; output low two cycles later (R2)
   task automatic wake_link();
      @(negedge clk);
      link_pwr = 1'b1;
      link_ctl = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R2", link_on, 1'b0);
      check("R2", link_on_h1, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", link_on, 1'b0);
      check("R1", link_on_h1, 1'b0);
      rst_n = 1'b1;
      check_low("R1", 3);

      // R3 / R5 / R2: full sweep of local ID against packet target
      for (int l = 0; l < (1 << NW); l++) begin
         for (int d = 0; d < (1 << NW); d++) begin
            @(negedge clk);
            local_id  = NW'(l);
            pkt_dest  = NW'(d);
            pkt_valid = 1'b1;
            if (((l + d) % 2) == 0) begin
               link_pwr = 1'b0; link_ctl = 1'b1;
            end else begin
               link_pwr = 1'b1; link_ctl = 1'b0;
            end
            @(negedge clk);
            pkt_valid = 1'b0;
            @(negedge clk);
            check((l == d) ? "R3" : "R5", link_on, l == d);
            wake_link();
         end
      end
      local_id = 6'd21;

      // R4: causes while awake are ignored
      @(negedge clk);
      pkt_valid = 1'b1; pkt_dest = 6'd21; phy_irq = 1'b1;
      @(negedge clk);
      pkt_valid = 1'b0; phy_irq = 1'b0;
      check_low("R4", 8);

      // R6 / R9: interrupt pulse, sticky request, wave shape
      @(negedge clk);
      link_pwr = 1'b0;
      phy_irq  = 1'b1;
      @(negedge clk);
      phy_irq  = 1'b0;
      check_wave("R6_R9", 24);

      // R7: bus reset without interrupt stops it
      @(negedge clk);
      bus_rst = 1'b1;
      @(negedge clk);
      bus_rst = 1'b0;
      check_low("R7", 8);

      // R8: bus reset blocked by pending interrupt
      @(negedge clk);
      phy_irq = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 24; k++) begin
         @(negedge clk);
         check("R8", link_on, ((k / H) % 2) == 0);
         check("R8", link_on_h1, (k % 2) == 0);
         if (k == 5) bus_rst = 1'b1;
         if (k == 6) bus_rst = 1'b0;
      end
      phy_irq = 1'b0;
      wake_link();

      // R10: unblocked bus reset beats a matching packet
      @(negedge clk);
      link_pwr = 1'b0;
      pkt_valid = 1'b1; pkt_dest = 6'd21; bus_rst = 1'b1;
      @(negedge clk);
      pkt_valid = 1'b0; bus_rst = 1'b0;
      check_low("R10", 8);

      // R11: stop mid-high, restart with a full high phase
      @(negedge clk);
      pkt_valid = 1'b1;
      @(negedge clk);
      pkt_valid = 1'b0;
      check_wave("R11", 2);
      @(negedge clk);
      link_pwr = 1'b1;
      @(negedge clk);
      @(negedge clk);
      link_pwr = 1'b0;
      pkt_valid = 1'b1;
      @(negedge clk);
      pkt_valid = 1'b0;
      check_wave("R11", 12);
      wake_link();

      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule